// File: doc/BRIEF.md
# Dual Data Pointer Address Unit

This block holds two 16-bit data pointers for the table-read and external-move instructions of a small processor core. It produces the memory address for each access and chooses the data register that the move reads from or writes to. A pointer can be loaded with a new value or stepped by one after an access. When circular mode is enabled for a pointer, stepping from the last address of a configured buffer range returns the pointer to the first address of that range. Two such ranges are defined by low and high bound inputs.

A small control byte sets the options. One bit turns circular mode on for each pointer. One bit removes the accumulator offset from indexed table reads. One bit sends moves that use pointer 1 to the B register instead of the accumulator. The address and the data select are combinational from the current pointer value and the request inputs. Loads, steps and control writes take effect at the next rising clock edge.

Top module: `dptr_addr_unit`

## Requirements
- R1: After reset both pointers read 0000h and the control byte is 00h. Circular mode is off, index-disable is off and redirect is off.
- R2: A load (ptrLd=1) writes ptrLdVal into the pointer chosen by ptrLdSel (0 or 1). The new value is visible on ptr0Q/ptr1Q after the next rising edge. The other pointer keeps its value.
- R3: With circular mode off, a step (ptrInc=1, pointer chosen by ptrIncSel) adds one to the pointer modulo 2^16, so FFFFh becomes 0000h.
- R4: With circular mode on, a pointer that is stepped while it equals the high bound of a range it lies in (low <= ptr <= high) is reloaded with that range's low bound. Range 0 is tested before range 1.
- R5: With circular mode on, a pointer inside a range but below its high bound steps by one.
- R6: With circular mode on, a pointer that lies outside both ranges steps by one, modulo 2^16.
- R7: Control bit 2 enables circular mode for pointer 0 and bit 3 enables it for pointer 1. Each bit affects only its own pointer.
- R8: With control bit 1 (index disable) at 0, an indexed read (opIndexed=1) puts out effAddr = pointer + zero-extended accIn, modulo 2^16. The pointer is selected by opSel. A non-indexed access puts out the pointer alone.
- R9: With control bit 1 at 1, effAddr equals the selected pointer for indexed reads, whatever value accIn has.
- R10: With control bit 0 (redirect) at 1, accesses through pointer 1 set srcIsB=1 and moveData=bIn. Accesses through pointer 0 always give srcIsB=0 and moveData=accIn. With bit 0 at 0, both pointers use the accumulator.
- R11: Redirect does not change the index. With redirect on, an indexed read through pointer 1 still adds accIn and never bIn.
- R12: When a load and a step target the same pointer in one cycle, the loaded value wins. When they target different pointers, both take effect.
- R13: Control bits 7 to 4 have no effect on the pointers, the address or the data select.
- R14: Without a load or a step, both pointers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Write strobe for the control byte |
| cfgWrData | input | 8 | Control byte value (bit0 redirect, bit1 index disable, bit2/bit3 circular enable for pointer 0/1) |
| ring0Lo | input | 16 | Low bound of circular range 0 |
| ring0Hi | input | 16 | High bound of circular range 0 |
| ring1Lo | input | 16 | Low bound of circular range 1 |
| ring1Hi | input | 16 | High bound of circular range 1 |
| ptrLd | input | 1 | Load a pointer |
| ptrLdSel | input | 1 | Pointer to load |
| ptrLdVal | input | 16 | Value to load |
| ptrInc | input | 1 | Step a pointer after an access |
| ptrIncSel | input | 1 | Pointer to step |
| accIn | input | 8 | Accumulator value (index and default data) |
| bIn | input | 8 | B register value (redirected data) |
| opSel | input | 1 | Pointer used by the current access |
| opIndexed | input | 1 | Current access is an indexed table read |
| ptr0Q | output | 16 | Pointer 0 value |
| ptr1Q | output | 16 | Pointer 1 value |
| effAddr | output | 16 | Effective memory address of the current access |
| srcIsB | output | 1 | Data register select: 1 for B, 0 for accumulator |
| moveData | output | 8 | Data value the move writes out |

## Verification
The indexed address is swept over all 256 accumulator values at a low pointer and at a pointer near FFFFh. This separates a correct modulo-2^16 sum from a truncated or saturated one. The same sweeps are then repeated with index disable set, with redirect set, and with only the upper control bits set. Step sequences go from below a range, through its high bound and back around, on two ranges of different lengths. Each pointer runs with its own circular bit alone, which exposes a swapped enable bit or a wrap that goes to the wrong low bound. Simultaneous load and step cycles, on the same pointer and on different pointers, settle the priority between the two.

// File: rtl/dpau_pkg.sv
package dpau_pkg;
  localparam int NUM_PTR  = 2;
  localparam int CFG_W    = 8;
  // control byte bit positions
  localparam int CFG_REDIR   = 0;
  localparam int CFG_IDXOFF  = 1;
  localparam int CFG_CIRC0   = 2;              // pointer n uses CFG_CIRC0 + n
  localparam int CFG_KEEP_W  = CFG_CIRC0 + NUM_PTR;
  localparam int REDIR_PTR   = 1;              // only this pointer may be redirected

  typedef struct packed {
    logic [NUM_PTR-1:0] load;
    logic [NUM_PTR-1:0] step;
    logic [NUM_PTR-1:0] circ;
    logic               idxOff;
  } pathCtl_t;
endpackage

// File: rtl/dpau_ctrl.sv
module dpau_ctrl
  import dpau_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              ptrLd,
  input  logic              ptrLdSel,
  input  logic              ptrInc,
  input  logic              ptrIncSel,
  input  logic              opSel,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] bIn,
  output pathCtl_t          ctl,
  output logic              srcIsB,
  output logic [DATA_W-1:0] moveData
);
  // Only the low bits carry meaning; the upper bits are dropped on write.
  logic [CFG_KEEP_W-1:0] cfgQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (cfgWr) begin
      cfgQ <= cfgWrData[CFG_KEEP_W-1:0];
    end
  end

  logic [NUM_PTR-1:0] loadVec;
  logic [NUM_PTR-1:0] stepVec;

  always_comb begin
    for (int p = 0; p < NUM_PTR; p++) begin
      loadVec[p] = ptrLd && (int'(ptrLdSel) == p);
      // a load on the same pointer overrides the step
      stepVec[p] = ptrInc && (int'(ptrIncSel) == p) && !loadVec[p];
    end
  end

  assign ctl.load   = loadVec;
  assign ctl.step   = stepVec;
  assign ctl.circ   = cfgQ[CFG_CIRC0 +: NUM_PTR];
  assign ctl.idxOff = cfgQ[CFG_IDXOFF];

  assign srcIsB   = cfgQ[CFG_REDIR] && (int'(opSel) == REDIR_PTR);
  assign moveData = srcIsB ? bIn : accIn;
endmodule

// File: rtl/dpau_path.sv
module dpau_path
  import dpau_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [ADDR_W-1:0] ptrLdVal,
  input  logic [ADDR_W-1:0] ring0Lo,
  input  logic [ADDR_W-1:0] ring0Hi,
  input  logic [ADDR_W-1:0] ring1Lo,
  input  logic [ADDR_W-1:0] ring1Hi,
  input  logic [DATA_W-1:0] accIn,
  input  logic              opSel,
  input  logic              opIndexed,
  output logic [ADDR_W-1:0] ptr0Q,
  output logic [ADDR_W-1:0] ptr1Q,
  output logic [ADDR_W-1:0] effAddr
);
  localparam int NUM_RING = 2;

  logic [NUM_RING-1:0][ADDR_W-1:0] ringLo;
  logic [NUM_RING-1:0][ADDR_W-1:0] ringHi;
  assign ringLo = {ring1Lo, ring0Lo};
  assign ringHi = {ring1Hi, ring0Hi};

  logic [NUM_PTR-1:0][ADDR_W-1:0] ptrQ;

  for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
    logic [NUM_RING-1:0] inRing;
    logic [NUM_RING-1:0] atTop;
    logic [ADDR_W-1:0]   stepped;

    for (genvar r = 0; r < NUM_RING; r++) begin : g_ring
      assign inRing[r] = (ptrQ[p] >= ringLo[r]) && (ptrQ[p] <= ringHi[r]);
      assign atTop[r]  = ptrQ[p] == ringHi[r];
    end

    always_comb begin
      stepped = ptrQ[p] + ADDR_W'(1);
      if (ctl.circ[p]) begin
        // the first range that contains the pointer decides
        if (inRing[0]) begin
          if (atTop[0]) stepped = ringLo[0];
        end else if (inRing[1]) begin
          if (atTop[1]) stepped = ringLo[1];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptrQ[p] <= '0;
      end else if (ctl.load[p]) begin
        ptrQ[p] <= ptrLdVal;
      end else if (ctl.step[p]) begin
        ptrQ[p] <= stepped;
      end
    end
  end

  logic [ADDR_W-1:0] basePtr;
  assign basePtr = ptrQ[opSel];
  assign effAddr = (opIndexed && !ctl.idxOff) ? basePtr + ADDR_W'(accIn) : basePtr;

  assign ptr0Q = ptrQ[0];
  assign ptr1Q = ptrQ[1];
endmodule

// File: rtl/dptr_addr_unit.sv
module dptr_addr_unit
  import dpau_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic [ADDR_W-1:0] ring0Lo,
  input  logic [ADDR_W-1:0] ring0Hi,
  input  logic [ADDR_W-1:0] ring1Lo,
  input  logic [ADDR_W-1:0] ring1Hi,
  input  logic              ptrLd,
  input  logic              ptrLdSel,
  input  logic [ADDR_W-1:0] ptrLdVal,
  input  logic              ptrInc,
  input  logic              ptrIncSel,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              opSel,
  input  logic              opIndexed,
  output logic [ADDR_W-1:0] ptr0Q,
  output logic [ADDR_W-1:0] ptr1Q,
  output logic [ADDR_W-1:0] effAddr,
  output logic              srcIsB,
  output logic [DATA_W-1:0] moveData
);
  pathCtl_t ctl;

  dpau_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWr     (cfgWr),
    .cfgWrData (cfgWrData),
    .ptrLd     (ptrLd),
    .ptrLdSel  (ptrLdSel),
    .ptrInc    (ptrInc),
    .ptrIncSel (ptrIncSel),
    .opSel     (opSel),
    .accIn     (accIn),
    .bIn       (bIn),
    .ctl       (ctl),
    .srcIsB    (srcIsB),
    .moveData  (moveData)
  );

  dpau_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .ptrLdVal  (ptrLdVal),
    .ring0Lo   (ring0Lo),
    .ring0Hi   (ring0Hi),
    .ring1Lo   (ring1Lo),
    .ring1Hi   (ring1Hi),
    .accIn     (accIn),
    .opSel     (opSel),
    .opIndexed (opIndexed),
    .ptr0Q     (ptr0Q),
    .ptr1Q     (ptr1Q),
    .effAddr   (effAddr)
  );
endmodule

// File: rtl/dpau_checker.sv
module dpau_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWr,
  input logic [7:0]        cfgWrData,
  input logic [ADDR_W-1:0] ring0Lo,
  input logic [ADDR_W-1:0] ring0Hi,
  input logic              ptrLd,
  input logic              ptrLdSel,
  input logic [ADDR_W-1:0] ptrLdVal,
  input logic              ptrInc,
  input logic              ptrIncSel,
  input logic [DATA_W-1:0] accIn,
  input logic              opSel,
  input logic              opIndexed,
  input logic [ADDR_W-1:0] ptr0Q,
  input logic [ADDR_W-1:0] ptr1Q,
  input logic [ADDR_W-1:0] effAddr,
  input logic              srcIsB,
  input logic [DATA_W-1:0] moveData
);
  // independent shadow of the control bits, from the write port
  logic [3:0] shCfg;
  always_ff @(posedge clk) begin
    if (!rstN) shCfg <= '0;
    else if (cfgWr) shCfg <= cfgWrData[3:0];
  end

  logic ld0, ld1, st0, st1;
  assign ld0 = ptrLd && !ptrLdSel;
  assign ld1 = ptrLd && ptrLdSel;
  assign st0 = ptrInc && !ptrIncSel && !ld0;
  assign st1 = ptrInc && ptrIncSel && !ld1;

  a_r2_load_p0: assert property (@(posedge clk) disable iff (!rstN)
    ld0 |=> ptr0Q == $past(ptrLdVal));

  a_r12_load_wins_p1: assert property (@(posedge clk) disable iff (!rstN)
    (ld1 && ptrInc && ptrIncSel) |=> ptr1Q == $past(ptrLdVal));

  a_r3_linear_p0: assert property (@(posedge clk) disable iff (!rstN)
    (st0 && !shCfg[2] && !cfgWr) |=> ptr0Q == $past(ptr0Q) + ADDR_W'(1));

  a_r4_wrap_p1: assert property (@(posedge clk) disable iff (!rstN)
    (st1 && shCfg[3] && !cfgWr && ptr1Q == ring0Hi && ptr1Q >= ring0Lo)
      |=> ptr1Q == $past(ring0Lo));

  a_r14_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ptrLd && !ptrInc) |=> (ptr0Q == $past(ptr0Q)) && (ptr1Q == $past(ptr1Q)));

  a_r9_no_index: assert property (@(posedge clk) disable iff (!rstN)
    (shCfg[1] && opIndexed) |-> effAddr == (opSel ? ptr1Q : ptr0Q));

  a_r10_ptr0_acc: assert property (@(posedge clk) disable iff (!rstN)
    !opSel |-> (!srcIsB && moveData == accIn));

  a_r11_acc_index: assert property (@(posedge clk) disable iff (!rstN)
    (shCfg[0] && !shCfg[1] && opIndexed && opSel) |-> effAddr == ptr1Q + ADDR_W'(accIn));
endmodule

bind dptr_addr_unit dpau_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgWrData(cfgWrData),
  .ring0Lo(ring0Lo), .ring0Hi(ring0Hi),
  .ptrLd(ptrLd), .ptrLdSel(ptrLdSel), .ptrLdVal(ptrLdVal),
  .ptrInc(ptrInc), .ptrIncSel(ptrIncSel), .accIn(accIn),
  .opSel(opSel), .opIndexed(opIndexed), .ptr0Q(ptr0Q), .ptr1Q(ptr1Q),
  .effAddr(effAddr), .srcIsB(srcIsB), .moveData(moveData)
);

// File: tb/dptr_addr_unit_bench.sv
module dptr_addr_unit_bench;
  localparam int CLK_P = 10;
  localparam logic [15:0] R0L = 16'h0100, R0H = 16'h0103;
  localparam logic [15:0] R1L = 16'h0200, R1H = 16'h0205;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWr;
  logic [7:0]  cfgWrData;
  logic [15:0] ring0Lo, ring0Hi, ring1Lo, ring1Hi;
  logic        ptrLd, ptrLdSel, ptrInc, ptrIncSel;
  logic [15:0] ptrLdVal;
  logic [7:0]  accIn, bIn;
  logic        opSel, opIndexed;
  logic [15:0] ptr0Q, ptr1Q, effAddr;
  logic        srcIsB;
  logic [7:0]  moveData;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_P/2) clk = ~clk;

  dptr_addr_unit u_dptr_addr_unit (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgWrData(cfgWrData),
    .ring0Lo(ring0Lo), .ring0Hi(ring0Hi), .ring1Lo(ring1Lo), .ring1Hi(ring1Hi),
    .ptrLd(ptrLd), .ptrLdSel(ptrLdSel), .ptrLdVal(ptrLdVal),
    .ptrInc(ptrInc), .ptrIncSel(ptrIncSel), .accIn(accIn), .bIn(bIn),
    .opSel(opSel), .opIndexed(opIndexed), .ptr0Q(ptr0Q), .ptr1Q(ptr1Q),
    .effAddr(effAddr), .srcIsB(srcIsB), .moveData(moveData)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setCfg(input logic [7:0] v);
    cfgWr = 1'b1; cfgWrData = v;
    step();
    cfgWr = 1'b0;
  endtask

  task automatic loadPtr(input logic sel, input logic [15:0] v);
    ptrLd = 1'b1; ptrLdSel = sel; ptrLdVal = v;
    step();
    ptrLd = 1'b0;
  endtask

  task automatic incPtr(input logic sel);
    ptrInc = 1'b1; ptrIncSel = sel;
    step();
    ptrInc = 1'b0;
  endtask

  function automatic logic [15:0] nextExp(input logic [15:0] p, input logic circ);
    if (circ) begin
      if (p >= R0L && p <= R0H) return (p == R0H) ? R0L : p + 16'd1;
      if (p >= R1L && p <= R1H) return (p == R1H) ? R1L : p + 16'd1;
    end
    return p + 16'd1;
  endfunction

  // step one pointer n times and compare against the model
  task automatic runSteps(input logic sel, input logic circ, input int n, input string tag);
    logic [15:0] cur;
    cur = sel ? ptr1Q : ptr0Q;
    for (int k = 0; k < n; k++) begin
      cur = nextExp(cur, circ);
      incPtr(sel);
      check(tag, sel ? ptr1Q : ptr0Q, cur);
    end
  endtask

  // sweep the accumulator for one pointer and index mode
  task automatic sweepAcc(input logic sel, input logic idxOff, input string tag);
    logic [15:0] base;
    opSel = sel; opIndexed = 1'b1;
    base = sel ? ptr1Q : ptr0Q;
    for (int a = 0; a < 256; a++) begin
      accIn = 8'(a);
      #1;
      check(tag, effAddr, idxOff ? base : base + 16'(a));
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    #(CLK_P * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgWr = 1'b0; cfgWrData = '0;
    ring0Lo = R0L; ring0Hi = R0H; ring1Lo = R1L; ring1Hi = R1H;
    ptrLd = 1'b0; ptrLdSel = 1'b0; ptrLdVal = '0;
    ptrInc = 1'b0; ptrIncSel = 1'b0;
    accIn = 8'h00; bIn = 8'h5A; opSel = 1'b1; opIndexed = 1'b1;
    step(); step();
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 ptr0", ptr0Q, 16'h0000);
    check("R1 ptr1", ptr1Q, 16'h0000);
    check("R1 effAddr", effAddr, 16'h0000);
    check("R1 srcIsB", 16'(srcIsB), 16'h0000);

    // R2 loads
    loadPtr(1'b0, 16'h1234);
    check("R2 ptr0 load", ptr0Q, 16'h1234);
    check("R2 ptr1 untouched", ptr1Q, 16'h0000);
    loadPtr(1'b1, 16'hFFC0);
    check("R2 ptr1 load", ptr1Q, 16'hFFC0);
    check("R2 ptr0 untouched", ptr0Q, 16'h1234);

    // R8 indexed sums, including 16-bit wrap on ptr1
    sweepAcc(1'b0, 1'b0, "R8 ptr0 index");
    sweepAcc(1'b1, 1'b0, "R8 ptr1 index wrap");
    opIndexed = 1'b0; accIn = 8'h77; #1;
    check("R8 non-indexed", effAddr, 16'hFFC0);

    // R9 index disable (bit1)
    setCfg(8'h02);
    sweepAcc(1'b0, 1'b1, "R9 ptr0 no index");
    sweepAcc(1'b1, 1'b1, "R9 ptr1 no index");

    // R10 / R11 redirect (bit0)
    setCfg(8'h01);
    bIn = 8'hC3;
    opSel = 1'b1; accIn = 8'h21; #1;
    check("R10 ptr1 srcIsB", 16'(srcIsB), 16'h0001);
    check("R10 ptr1 data from B", 16'(moveData), 16'h00C3);
    opSel = 1'b0; #1;
    check("R10 ptr0 srcIsB", 16'(srcIsB), 16'h0000);
    check("R10 ptr0 data from acc", 16'(moveData), 16'h0021);
    sweepAcc(1'b1, 1'b0, "R11 redirect keeps acc index");
    setCfg(8'h00);
    opSel = 1'b1; accIn = 8'h21; #1;
    check("R10 ptr1 no redirect", 16'(moveData), 16'h0021);

    // R3 linear step with 16-bit wrap
    loadPtr(1'b0, 16'hFFFE);
    runSteps(1'b0, 1'b0, 3, "R3 linear ptr0");
    check("R3 ptr1 untouched", ptr1Q, 16'hFFC0);
    loadPtr(1'b1, 16'h0102);
    runSteps(1'b1, 1'b0, 4, "R3 linear through range");

    // R4 R5 R6 circular on both pointers
    setCfg(8'h0C);
    loadPtr(1'b0, 16'h00FE);
    runSteps(1'b0, 1'b1, 12, "R4 R5 R6 ptr0 ring0");
    loadPtr(1'b1, 16'h01FD);
    runSteps(1'b1, 1'b1, 16, "R4 R5 R6 ptr1 ring1");
    loadPtr(1'b0, 16'hFFFF);
    runSteps(1'b0, 1'b1, 2, "R6 outside wraps 16-bit");

    // R7 per-pointer enables
    setCfg(8'h04);
    loadPtr(1'b0, R0H); loadPtr(1'b1, R0H);
    incPtr(1'b0);
    check("R7 ptr0 circular", ptr0Q, R0L);
    incPtr(1'b1);
    check("R7 ptr1 linear", ptr1Q, R0H + 16'd1);
    setCfg(8'h08);
    loadPtr(1'b0, R1H); loadPtr(1'b1, R1H);
    incPtr(1'b0);
    check("R7 ptr0 linear", ptr0Q, R1H + 16'd1);
    incPtr(1'b1);
    check("R7 ptr1 circular", ptr1Q, R1L);

    // R12 load versus step
    ptrLd = 1'b1; ptrLdSel = 1'b0; ptrLdVal = 16'hBEEF;
    ptrInc = 1'b1; ptrIncSel = 1'b0;
    step();
    check("R12 same pointer load wins", ptr0Q, 16'hBEEF);
    ptrLdSel = 1'b1; ptrLdVal = 16'h4000; ptrIncSel = 1'b0;
    step();
    ptrLd = 1'b0; ptrInc = 1'b0;
    check("R12 other pointer loaded", ptr1Q, 16'h4000);
    check("R12 other pointer stepped", ptr0Q, 16'hBEF0);

    // R14 hold
    step(); step();
    check("R14 ptr0 hold", ptr0Q, 16'hBEF0);
    check("R14 ptr1 hold", ptr1Q, 16'h4000);

    // R13 upper control bits ignored
    setCfg(8'hF0);
    loadPtr(1'b1, 16'hFFF8);
    sweepAcc(1'b1, 1'b0, "R13 index still added");
    opSel = 1'b1; bIn = 8'h99; accIn = 8'h11; #1;
    check("R13 no redirect", 16'(srcIsB), 16'h0000);
    check("R13 data acc", 16'(moveData), 16'h0011);
    loadPtr(1'b0, R0H);
    incPtr(1'b0);
    check("R13 no circular", ptr0Q, R0H + 16'd1);

    summary();
    $finish;
  end
endmodule